// File: doc/BRIEF.md
# Packet-Mode I2C Transfer Header Decoder

This block sits between a word-wide transmit queue and an I2C bus engine. Software describes each bus transfer in-band: it pushes three 32-bit header words followed, for writes, by the payload words. The decoder parses the header into a transfer descriptor, starts the bus engine with a one-cycle pulse, and holds the descriptor steady while the transfer runs.

For a write it unpacks the payload words into a byte stream, least significant byte first, and stops after exactly the requested number of bytes, so a final partial word gives up only its valid low bytes. For a read it takes no payload words and counts byte slots that the engine accepts. When the last byte slot is accepted it issues a one-cycle completion pulse that carries the end-of-transfer condition. A header whose protocol field is not I2C raises a one-cycle error pulse, and its header is dropped without starting the engine.

The bit-level bus signalling is not part of this block. The engine is represented by a valid/ready byte handshake.

Top module: `i2c_pkt_decoder`

## Requirements
- R1: After reset, wordReady is 1 and busy, xferStart, byteValid, done and protoErr are all 0.
- R2: Header word 0 carries the header size in bits 29:28, the packet id in bits 23:16, the controller id in bits 15:12 and the protocol in bits 7:4. Protocol value 1 means I2C. These fields appear on descHdrSize, descPktId and descCtlId.
- R3: Bits 11:0 of header word 1 hold the byte count minus one. descCount shows the count plus one, and exactly that many bytes are accepted before completion.
- R4: Header word 2 flags map to the descriptor as follows: bit 22 to descHighSpeed, bit 21 to descNackGo, bit 20 to descStartByte, bit 19 to descRead, bit 18 to descTenBit and bit 17 to descIrqEn.
- R5: When bit 18 is clear, the 7-bit address is taken from word 2 bits 7:1 and placed zero-extended on descAddr. When bit 18 is set, descAddr is word 2 bits 9:0.
- R6: Write payload bytes leave on byteData in little-endian order within each word. A final partial word consumes exactly one word, and the word that follows it is treated as a new header word 0.
- R7: descEnd and doneEnd encode the end of the transfer: 0 is stop, 1 is repeated start (word 2 bit 16) and 2 is continue (word 2 bit 15). When both bits are set, repeated start wins. Stop applies when neither is set.
- R8: When header word 0 has a protocol other than 1, protoErr pulses for one cycle in the cycle after that word is accepted. The next two words are taken and dropped, and xferStart does not pulse.
- R9: A read packet takes no payload words, and wordReady stays 0 while it is busy. It offers count byte slots with byteData equal to 0, and the next word is a new header word 0.
- R10: xferStart pulses for one cycle in the cycle after the third header word is accepted. The descriptor outputs hold steady while busy is 1.
- R11: done pulses for one cycle in the cycle after the last byte slot is accepted. doneEnd equals the packet's end code during that pulse.
- R12: While byteValid is 1 and byteReady is 0, byteValid stays 1 and byteData holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Transmit queue word available |
| wordData | input | 32 | Transmit queue word |
| wordReady | output | 1 | Decoder takes the word this cycle |
| xferStart | output | 1 | One-cycle start pulse to the bus engine |
| busy | output | 1 | A transfer is in progress |
| descHdrSize | output | 2 | Header size field |
| descPktId | output | 8 | Packet id |
| descCtlId | output | 4 | Controller id |
| descCount | output | 13 | Byte count (1 to 4096) |
| descAddr | output | 10 | Target address |
| descTenBit | output | 1 | 10-bit addressing |
| descRead | output | 1 | Read transfer |
| descHighSpeed | output | 1 | High-speed mode |
| descNackGo | output | 1 | Continue on NACK |
| descStartByte | output | 1 | Send start byte |
| descIrqEn | output | 1 | Completion interrupt enable |
| descEnd | output | 2 | End code (0 stop, 1 restart, 2 continue) |
| byteValid | output | 1 | Byte slot offered to the engine |
| byteData | output | 8 | Write byte (0 for reads) |
| byteReady | input | 1 | Engine accepts the byte slot |
| done | output | 1 | One-cycle completion pulse |
| doneEnd | output | 2 | End code that goes with done |
| protoErr | output | 1 | One-cycle pulse for a header that is not I2C |

## Verification
The bench sends writes of 5, 4, 2 and 1 bytes, so the last payload word holds one, four, two and one valid bytes. A 4-byte write shows that no extra word is fetched, and the short words show that the unused lanes are dropped and the next word is read as a header. Packets use both the 7-bit and the 10-bit address forms with distinct flag patterns, which would expose a swapped bit or a wrong shift. A read packet is followed immediately by a write, so any payload word taken by mistake would shift the next header. A packet with a bad protocol field, followed by a good packet, shows that the decoder recovers after exactly three dropped words. byteReady stalls on a fixed pattern throughout, which tests that the byte handshake holds its data.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 12;
  localparam int LEN_W   = CNT_W + 1;
  localparam int LANES   = WORD_W / BYTE_W;
  localparam int LANE_W  = $clog2(LANES);
  localparam int ADDR_W  = 10;
  localparam logic [3:0] PROTO_I2C = 4'd1;

  typedef enum logic [1:0] {
    END_STOP    = 2'd0,
    END_RESTART = 2'd1,
    END_CONT    = 2'd2
  } endKind_t;

  typedef struct packed {
    logic capHdr0;
    logic capCount;
    logic capCtrl;
    logic loadPayload;
    logic byteTaken;
  } strobes_t;

  typedef struct packed {
    logic [1:0]        hdrSize;
    logic [7:0]        pktId;
    logic [3:0]        ctlId;
    logic [LEN_W-1:0]  count;
    logic [ADDR_W-1:0] addr;
    logic              tenBit;
    logic              isRead;
    logic              highSpeed;
    logic              nackGo;
    logic              startByte;
    logic              irqEn;
    endKind_t          endKind;
  } desc_t;
endpackage

// File: rtl/i2c_pkt_datapath.sv
module i2c_pkt_datapath
  import i2c_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [WORD_W-1:0] wordData,
  output desc_t             desc,
  output logic              protoOk,
  output logic              wantRead,
  output logic              lastByte,
  output logic              laneLast,
  output logic [BYTE_W-1:0] byteData
);
  logic [LEN_W-1:0]  remaining;
  logic [WORD_W-1:0] shifter;
  logic [LANE_W-1:0] lane;
  logic              unusedBits;

  assign protoOk  = (wordData[7:4] == PROTO_I2C);
  assign wantRead = wordData[19];
  assign lastByte = (remaining == LEN_W'(1));
  assign laneLast = (lane == LANE_W'(LANES - 1));
  assign byteData = desc.isRead ? '0 : shifter[BYTE_W-1:0];
  assign unusedBits = ^{wordData[31:30], wordData[27:24], wordData[3:0], wordData[14:11]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      desc      <= '0;
      remaining <= '0;
      shifter   <= '0;
      lane      <= '0;
    end else begin
      if (strb.capHdr0) begin
        desc.hdrSize <= wordData[29:28];
        desc.pktId   <= wordData[23:16];
        desc.ctlId   <= wordData[15:12];
      end
      if (strb.capCount) begin
        desc.count <= LEN_W'(wordData[CNT_W-1:0]) + LEN_W'(1);
        remaining  <= LEN_W'(wordData[CNT_W-1:0]) + LEN_W'(1);
      end
      if (strb.capCtrl) begin
        desc.highSpeed <= wordData[22];
        desc.nackGo    <= wordData[21];
        desc.startByte <= wordData[20];
        desc.isRead    <= wordData[19];
        desc.tenBit    <= wordData[18];
        desc.irqEn     <= wordData[17];
        desc.addr      <= wordData[18] ? wordData[ADDR_W-1:0] : {3'b000, wordData[7:1]};
        if (wordData[16])      desc.endKind <= END_RESTART;
        else if (wordData[15]) desc.endKind <= END_CONT;
        else                   desc.endKind <= END_STOP;
      end
      if (strb.loadPayload) begin
        shifter <= wordData;
        lane    <= '0;
      end else if (strb.byteTaken) begin
        shifter <= shifter >> BYTE_W;
        lane    <= lane + LANE_W'(1);
      end
      if (strb.byteTaken) remaining <= remaining - LEN_W'(1);
    end
  end
endmodule

// File: rtl/i2c_pkt_ctrl.sv
module i2c_pkt_ctrl
  import i2c_pkt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wordValid,
  input  logic     byteReady,
  input  logic     protoOk,
  input  logic     wantRead,
  input  logic     lastByte,
  input  logic     laneLast,
  output strobes_t strb,
  output logic     wordReady,
  output logic     byteValid,
  output logic     busy,
  output logic     xferStart,
  output logic     done,
  output logic     protoErr
);
  typedef enum logic [2:0] {
    ST_HDR0, ST_HDR1, ST_HDR2, ST_SKIP1, ST_SKIP2, ST_FETCH, ST_SEND, ST_RDSLOT
  } state_t;

  state_t state, nextState;
  logic   wordTake, slotTake;

  assign wordReady = (state == ST_HDR0) || (state == ST_HDR1) || (state == ST_HDR2) ||
                     (state == ST_SKIP1) || (state == ST_SKIP2) || (state == ST_FETCH);
  assign byteValid = (state == ST_SEND) || (state == ST_RDSLOT);
  assign busy      = (state == ST_FETCH) || (state == ST_SEND) || (state == ST_RDSLOT);
  assign wordTake  = wordValid && wordReady;
  assign slotTake  = byteValid && byteReady;

  always_comb begin
    strb             = '0;
    strb.capHdr0     = wordTake && (state == ST_HDR0) && protoOk;
    strb.capCount    = wordTake && (state == ST_HDR1);
    strb.capCtrl     = wordTake && (state == ST_HDR2);
    strb.loadPayload = wordTake && (state == ST_FETCH);
    strb.byteTaken   = slotTake;
    nextState = state;
    case (state)
      ST_HDR0:  if (wordTake) nextState = protoOk ? ST_HDR1 : ST_SKIP1;
      ST_HDR1:  if (wordTake) nextState = ST_HDR2;
      ST_HDR2:  if (wordTake) nextState = wantRead ? ST_RDSLOT : ST_FETCH;
      ST_SKIP1: if (wordTake) nextState = ST_SKIP2;
      ST_SKIP2: if (wordTake) nextState = ST_HDR0;
      ST_FETCH: if (wordTake) nextState = ST_SEND;
      ST_SEND:
        if (slotTake) begin
          if (lastByte)      nextState = ST_HDR0;
          else if (laneLast) nextState = ST_FETCH;
        end
      ST_RDSLOT: if (slotTake && lastByte) nextState = ST_HDR0;
      default:   nextState = ST_HDR0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HDR0;
      xferStart <= 1'b0;
      done      <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      state     <= nextState;
      xferStart <= strb.capCtrl;
      done      <= slotTake && lastByte;
      protoErr  <= wordTake && (state == ST_HDR0) && !protoOk;
    end
  end
endmodule

// File: rtl/i2c_pkt_decoder.sv
module i2c_pkt_decoder
  import i2c_pkt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  input  logic [31:0] wordData,
  output logic        wordReady,
  output logic        xferStart,
  output logic        busy,
  output logic [1:0]  descHdrSize,
  output logic [7:0]  descPktId,
  output logic [3:0]  descCtlId,
  output logic [12:0] descCount,
  output logic [9:0]  descAddr,
  output logic        descTenBit,
  output logic        descRead,
  output logic        descHighSpeed,
  output logic        descNackGo,
  output logic        descStartByte,
  output logic        descIrqEn,
  output logic [1:0]  descEnd,
  output logic        byteValid,
  output logic [7:0]  byteData,
  input  logic        byteReady,
  output logic        done,
  output logic [1:0]  doneEnd,
  output logic        protoErr
);
  strobes_t strb;
  desc_t    desc;
  logic     protoOk, wantRead, lastByte, laneLast;

  i2c_pkt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .byteReady(byteReady),
    .protoOk(protoOk), .wantRead(wantRead), .lastByte(lastByte), .laneLast(laneLast),
    .strb(strb), .wordReady(wordReady), .byteValid(byteValid), .busy(busy),
    .xferStart(xferStart), .done(done), .protoErr(protoErr)
  );

  i2c_pkt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordData(wordData), .desc(desc),
    .protoOk(protoOk), .wantRead(wantRead), .lastByte(lastByte),
    .laneLast(laneLast), .byteData(byteData)
  );

  assign descHdrSize   = desc.hdrSize;
  assign descPktId     = desc.pktId;
  assign descCtlId     = desc.ctlId;
  assign descCount     = desc.count;
  assign descAddr      = desc.addr;
  assign descTenBit    = desc.tenBit;
  assign descRead      = desc.isRead;
  assign descHighSpeed = desc.highSpeed;
  assign descNackGo    = desc.nackGo;
  assign descStartByte = desc.startByte;
  assign descIrqEn     = desc.irqEn;
  assign descEnd       = desc.endKind;
  assign doneEnd       = desc.endKind;
endmodule

// File: rtl/i2c_pkt_decoder_chk.sv
module i2c_pkt_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wordValid,
  input logic [31:0] wordData,
  input logic        wordReady,
  input logic        xferStart,
  input logic        busy,
  input logic [1:0]  descHdrSize,
  input logic [7:0]  descPktId,
  input logic [3:0]  descCtlId,
  input logic [12:0] descCount,
  input logic [9:0]  descAddr,
  input logic        descTenBit,
  input logic        descRead,
  input logic        descHighSpeed,
  input logic        descNackGo,
  input logic        descStartByte,
  input logic        descIrqEn,
  input logic [1:0]  descEnd,
  input logic        byteValid,
  input logic [7:0]  byteData,
  input logic        byteReady,
  input logic        done,
  input logic [1:0]  doneEnd,
  input logic        protoErr
);
  logic unusedChk;
  assign unusedChk = ^{wordValid, wordData, descHdrSize, descPktId, descCtlId,
                       descTenBit, descHighSpeed, descNackGo, descStartByte,
                       descIrqEn, descEnd, doneEnd};

  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteReady) |=> (byteValid && $stable(byteData)));

  // R8
  err_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> (!xferStart && !busy));

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> !protoErr);

  // R10
  desc_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(descAddr) && $stable(descCount) && $stable(descRead)));

  // R9
  read_no_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && descRead) |-> !wordReady);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind i2c_pkt_decoder i2c_pkt_decoder_chk u_chk (.*);

// File: tb/i2c_pkt_decoder_bench.sv
module i2c_pkt_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        byteReady = 1'b0;
  logic        wordReady, xferStart, busy, descTenBit, descRead, descHighSpeed;
  logic        descNackGo, descStartByte, descIrqEn, byteValid, done, protoErr;
  logic [1:0]  descHdrSize, descEnd, doneEnd;
  logic [7:0]  descPktId, byteData;
  logic [3:0]  descCtlId;
  logic [12:0] descCount;
  logic [9:0]  descAddr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int errSeen = 0;
  int errExp = 0;
  logic [7:0]  byteQ[$];
  logic [46:0] descQ[$];
  logic [1:0]  endQ[$];
  logic        holdPending = 1'b0;
  logic [7:0]  holdData = '0;

  always #4 clk = ~clk;

  i2c_pkt_decoder u_i2c_pkt_decoder (.*);

  function automatic logic [46:0] packDesc(logic rd, logic ten, logic hs, logic ng, logic sb,
      logic ie, logic [1:0] en, logic [9:0] ad, logic [12:0] cn, logic [7:0] pid,
      logic [3:0] cid, logic [1:0] hsz);
    return {rd, ten, hs, ng, sb, ie, en, ad, cn, pid, cid, hsz};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushWord(input logic [31:0] w);
    bit got;
    wordValid = 1'b1;
    wordData  = w;
    do begin
      @(negedge clk);
      got = wordReady;
      @(posedge clk);
      #1;
    end while (!got);
    wordValid = 1'b0;
    wordData  = '0;
  endtask

  task automatic sendPkt(input bit rd, input int len, input bit ten, input logic [9:0] ad,
      input bit rs, input bit ct, input bit hs, input bit ng, input bit sb, input bit ie,
      input logic [7:0] pid, input logic [3:0] cid, input logic [1:0] hsz, input logic [7:0] seed);
    logic [31:0] w2;
    logic [1:0]  en;
    logic [9:0]  adExp;
    logic [31:0] pw;
    en    = rs ? 2'd1 : (ct ? 2'd2 : 2'd0);
    adExp = ten ? ad : {3'b000, ad[6:0]};
    w2 = (32'(hs) << 22) | (32'(ng) << 21) | (32'(sb) << 20) | (32'(rd) << 19) |
         (32'(ten) << 18) | (32'(ie) << 17) | (32'(rs) << 16) | (32'(ct) << 15);
    w2 = ten ? (w2 | 32'(ad)) : (w2 | (32'(ad[6:0]) << 1));
    descQ.push_back(packDesc(rd, ten, hs, ng, sb, ie, en, adExp, 13'(len), pid, cid, hsz));
    endQ.push_back(en);
    for (int i = 0; i < len; i++) byteQ.push_back(rd ? 8'h00 : 8'(seed + 8'(i)));
    pushWord((32'(hsz) << 28) | (32'(pid) << 16) | (32'(cid) << 12) | 32'h10);
    pushWord(32'(len - 1));
    pushWord(w2);
    if (!rd) begin
      for (int wi = 0; wi < (len + 3) / 4; wi++) begin
        pw = '0;
        for (int b = 0; b < 4; b++)
          if (wi * 4 + b < len) pw[b*8 +: 8] = 8'(seed + 8'(wi * 4 + b));
        pushWord(pw);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 byteReady = ((cyc % 5) != 2);
  end

  always @(negedge clk) if (rstN) begin
    if (holdPending) begin
      check(byteValid && byteData == holdData, "R12 held byte", {byteValid, byteData}, {1'b1, holdData});
      holdPending = 1'b0;
    end
    if (byteValid && !byteReady) begin
      holdPending = 1'b1;
      holdData    = byteData;
    end
    if (byteValid && byteReady) begin
      if (byteQ.size() == 0) check(1'b0, "R3 R6 extra byte slot", byteData, 0);
      else begin
        logic [7:0] e;
        e = byteQ.pop_front();
        check(byteData == e, "R6 R9 byte value", byteData, e);
      end
    end
    if (xferStart) begin
      logic [46:0] a;
      a = packDesc(descRead, descTenBit, descHighSpeed, descNackGo, descStartByte, descIrqEn,
                   descEnd, descAddr, descCount, descPktId, descCtlId, descHdrSize);
      if (descQ.size() == 0) check(1'b0, "R8 R10 unexpected start", a, 0);
      else begin
        logic [46:0] e;
        e = descQ.pop_front();
        check(a == e, "R2 R3 R4 R5 R7 R10 descriptor", a, e);
      end
    end
    if (done) begin
      if (endQ.size() == 0) check(1'b0, "R11 unexpected done", doneEnd, 0);
      else begin
        logic [1:0] e;
        e = endQ.pop_front();
        check(doneEnd == e, "R7 R11 done end code", doneEnd, e);
      end
    end
    if (protoErr) errSeen++;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(wordReady && !busy && !xferStart && !byteValid && !done && !protoErr,
          "R1 reset state", {wordReady, busy, xferStart, byteValid, done, protoErr}, 6'b100000);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    sendPkt(0, 5, 0, 10'h05A, 1, 0, 0, 0, 0, 1, 8'h11, 4'h3, 2'd0, 8'h40);
    sendPkt(0, 4, 1, 10'h2C5, 0, 0, 0, 1, 1, 0, 8'hA5, 4'hC, 2'd2, 8'h80);
    sendPkt(1, 3, 0, 10'h033, 0, 1, 1, 0, 0, 1, 8'h01, 4'h0, 2'd1, 8'h00);
    sendPkt(0, 1, 0, 10'h07F, 0, 0, 0, 0, 1, 0, 8'hFE, 4'h7, 2'd3, 8'hC3);
    pushWord(32'h1234_5620);
    errExp++;
    pushWord(32'h0000_0007);
    pushWord(32'h0008_0000);
    sendPkt(0, 2, 0, 10'h048, 1, 1, 1, 1, 0, 0, 8'h5C, 4'h9, 2'd0, 8'hE0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(byteQ.size() == 0, "R3 all bytes delivered", byteQ.size(), 0);
    check(descQ.size() == 0, "R10 all starts seen", descQ.size(), 0);
    check(endQ.size() == 0, "R11 all dones seen", endQ.size(), 0);
    check(errSeen == errExp, "R8 protocol error pulses", errSeen, errExp);
    check(!busy && wordReady, "R6 R9 idle after packets", {busy, wordReady}, 2'b01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule